// File: doc/BRIEF.md
# Set-Clear Peripheral Clock Gate Bank

This block holds the gate state for up to 64 peripheral clocks, split into two groups of 32. Software never reads a gate word, edits it and writes it back. Each group has one write address that turns clocks on and another that turns them off. A one in the written word acts on the clock at that bit. A zero leaves that clock as it was. Two concurrent drivers can therefore each touch their own clocks without a lock.

Each group also has two read-only views. The request view shows the state software asked for. The actual view shows the state the clock cells have reached. The cells are modelled as enables that follow the request after a fixed lag of two clock cycles, and the per-clock output enable equals the actual view. After an on or off write, software polls the actual view until it agrees with the request. Clock index n lives in group 1 when n is above 31 and in group 0 otherwise, at bit n mod 32. Index 2 drives the static memory controller, so it comes out of reset running.

Top module: `clk_gate_bank`

## Requirements
- R1: While reset is held and right after it is released, request and actual state are 64'h0000_0000_0000_0004, so only index 2 is on, and clk_on equals that value.
- R2: A write to byte address 0x24 (group 0) or 0x34 (group 1) sets the request bit for every one in wdata. Zero bits leave their request bits unchanged.
- R3: A write to 0x28 (group 0) or 0x38 (group 1) clears the request bit for every one in wdata. Zero bits leave their request bits unchanged. Index 2 can be cleared this way.
- R4: Reading 0x2C (group 0) or 0x3C (group 1) returns the request word. It shows a write in the cycle after the write edge.
- R5: The actual state, read at 0x30 (group 0) or 0x40 (group 1), and clk_on both equal the request state as it stood two rising edges earlier. A change written at edge E appears at edge E+2.
- R6: clk_on[32*g+b] is the actual bit b of group g.
- R7: Indices 32 to 35 (group 1 bits 3:0) are reserved. Their request bits, actual bits and clk_on bits are always zero, even when written with ones.
- R8: Writes to any address other than the four on/off addresses change nothing. Reads of the on/off addresses and of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 8 | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, a combinational function of addr |
| clk_on | output | 64 | Per-clock enable, one bit per clock index |

## Verification
The assertions assume one write at most per cycle, with addr and wdata stable around the rising edge. They also assume reset is asserted from time zero, so the two-cycle lag check starts only after two edges out of reset. The stimulus drives every input on the falling edge and holds it through the next rising edge. It writes and reads only 8-bit byte addresses, and it also hits the read-only and unmapped addresses, so the assumptions hold while the ignore cases are still exercised.

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int NGRP = 2,
  parameter int LAG = 2,
  parameter logic [AW-1:0] BASE = 8'h24,
  parameter logic [AW-1:0] STRIDE = 8'h10,
  parameter logic [63:0] RST_ON = 64'h0000_0000_0000_0004,
  parameter logic [63:0] RSVD = 64'h0000_000F_0000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [NGRP*DW-1:0] clk_on
);
  localparam int N = NGRP * DW;
  localparam logic [N-1:0] RST_V = N'(RST_ON) & ~N'(RSVD);

  logic [N-1:0] req_q;
  logic [N-1:0] pipe_q [LAG];
  logic [N-1:0] set_m, clr_m;
  logic [DW-1:0] rd_g [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [AW-1:0] A_SET = AW'(BASE + g * STRIDE);
    localparam logic [AW-1:0] A_CLR = AW'(A_SET + 4);
    localparam logic [AW-1:0] A_REQ = AW'(A_SET + 8);
    localparam logic [AW-1:0] A_ACT = AW'(A_SET + 12);
    assign set_m[g*DW +: DW] = (wr_en && addr == A_SET) ? wdata : '0;
    assign clr_m[g*DW +: DW] = (wr_en && addr == A_CLR) ? wdata : '0;
    assign rd_g[g] = (addr == A_REQ) ? req_q[g*DW +: DW] :
                     (addr == A_ACT) ? clk_on[g*DW +: DW] : '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) req_q <= RST_V;
    else        req_q <= (req_q | set_m) & ~clr_m & ~N'(RSVD);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pipe_q[0] <= RST_V;
    else        pipe_q[0] <= req_q;

  for (genvar i = 1; i < LAG; i++) begin : g_lag
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pipe_q[i] <= RST_V;
      else        pipe_q[i] <= pipe_q[i-1];
  end

  assign clk_on = pipe_q[LAG-1];

  always_comb begin
    rdata = '0;
    for (int g = 0; g < NGRP; g++) rdata = rdata | rd_g[g];
  end
endmodule

// File: rtl/clk_gate_bank_chk.sv
module clk_gate_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [7:0]  addr,
  input logic [31:0] wdata,
  input logic [63:0] req,
  input logic [63:0] clk_on
);
  logic [1:0] since;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since <= '0;
    else if (since != 2'd2) since <= since + 2'd1;

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h24) |=> ((req[31:0] & $past(wdata)) == $past(wdata)));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h38) |=> ((req[63:32] & $past(wdata)) == 32'h0));

  // R5
  act_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd2) |-> (clk_on == $past(req, 2)));

  // R7
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req[35:32] == 4'h0) && (clk_on[35:32] == 4'h0));

  // R8
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != 8'h24 && addr != 8'h28 && addr != 8'h34 && addr != 8'h38)
    |=> $stable(req));
endmodule

bind clk_gate_bank clk_gate_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .req(req_q), .clk_on(clk_on)
);

// File: tb/tb_clk_gate_bank.sv
`timescale 1ns/1ps
module tb_clk_gate_bank;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [63:0] clk_on;

  clk_gate_bank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                     .wdata(wdata), .rdata(rdata), .clk_on(clk_on));

  always #2.5 clk = ~clk;

  localparam logic [63:0] RV = 64'h4;
  int tests = 0, fails = 0;
  logic [63:0] m_req = RV, m_act = RV;
  logic [63:0] hist[$] = '{RV, RV, RV};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = RV; hist = '{RV, RV, RV}; m_act = RV;
    end else begin
      if (wr_en) begin
        case (addr)
          8'h24: m_req[31:0]  = m_req[31:0]  | wdata;
          8'h28: m_req[31:0]  = m_req[31:0]  & ~wdata;
          8'h34: m_req[63:32] = m_req[63:32] | wdata;
          8'h38: m_req[63:32] = m_req[63:32] & ~wdata;
          default: ;
        endcase
        m_req[35:32] = 4'h0;
      end
      hist.push_back(m_req);
      while (hist.size() > 3) void'(hist.pop_front());
      m_act = hist[0];
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) chk("R5 R6 per-cycle clk_on", clk_on, m_act);

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h2C: return m_req[31:0];
      8'h3C: return m_req[63:32];
      8'h30: return m_act[31:0];
      8'h40: return m_act[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(string tag, logic [7:0] a);
    @(negedge clk); addr = a; #1;
    chk(tag, {32'h0, rdata}, {32'h0, exp_rd(a)});
  endtask

  initial begin
    #(200000 * 5);
    fails++; tests++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 clk_on in reset", clk_on, RV);
    rst_n = 1;
    @(negedge clk);
    chk("R1 clk_on after reset", clk_on, RV);
    rd("R1 req0", 8'h2C); rd("R1 act0", 8'h30); rd("R1 req1", 8'h3C);

    wr(8'h24, 32'hF0);
    chk("R4 req after set", {32'h0, m_req[31:0]}, 64'hF4);
    rd("R4 req0 read", 8'h2C);
    chk("R5 not yet at E+1", clk_on, RV);
    @(negedge clk);
    chk("R5 visible at E+2", clk_on, 64'hF4);
    rd("R5 act0 read", 8'h30);

    wr(8'h24, 32'h0); repeat (2) @(negedge clk);
    chk("R2 zero set no effect", clk_on, 64'hF4);
    wr(8'h28, 32'h10); repeat (2) @(negedge clk);
    chk("R3 clear one bit", clk_on, 64'hE4);
    wr(8'h28, 32'h4); repeat (2) @(negedge clk);
    chk("R3 clear index 2", clk_on, 64'hE0);

    wr(8'h34, 32'hFFFF_FFFF); rd("R7 req1 reserved", 8'h3C);
    repeat (2) @(negedge clk);
    chk("R6 R7 group1 clk_on", clk_on, 64'hFFFF_FFF0_0000_00E0);
    wr(8'h38, 32'h100); repeat (2) @(negedge clk);
    chk("R6 clear index 40", clk_on[40] ? 64'h1 : 64'h0, 64'h0);

    wr(8'h2C, 32'hFFFF_FFFF); wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h40, 32'h0);
    repeat (2) @(negedge clk);
    chk("R8 read-only writes ignored", clk_on, 64'hFFFF_FEF0_0000_00E0);
    rd("R8 set addr reads zero", 8'h24);
    rd("R8 clr addr reads zero", 8'h38);
    rd("R8 unmapped reads zero", 8'h44);

    for (int i = 0; i < 300; i++) begin
      logic [7:0] a;
      case ($urandom_range(0, 5))
        0: a = 8'h24; 1: a = 8'h28; 2: a = 8'h34; 3: a = 8'h38;
        4: a = 8'h3C; default: a = 8'h10;
      endcase
      wr(a, $urandom);
      if (i % 3 == 0) rd("R4 R5 random read", 8'h2C + 8'(($urandom_range(0, 3)) * 4));
      if (i % 5 == 0) rd("R7 random read1", 8'h3C);
    end
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule